// File: doc/BRIEF.md
# DRAM Row-Buffer Command Sequencer

This block sits between a request stream and a multi-bank DRAM device. Each request names a bank, a row and a column, plus a read/write flag. The block turns each request into the commands the device needs on one shared command/address bus. A request that hits the row already open in its bank goes straight to a column command. A request to an idle bank first opens the row. A request to a bank holding a different row closes that row, opens the new one, and then issues the column command. Only one command is driven per cycle.

The block keeps a table of open rows, one entry per bank, together with per-bank down-counters. These counters hold back each command until the fixed minimum gap since the previous command to that bank has elapsed. A free-running interval timer raises periodic refresh. Before a refresh goes out, every open bank is closed. New requests are held off until the refresh has finished. Requests are served one at a time, in arrival order, through a valid/ready handshake. A hit or miss pulse marks the cycle in which each request is accepted.

Top module: `dram_cmd_seq`

## Requirements
- R1: A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after acceptance through the cycle in which the request's READ/WRITE is driven. It is high again in the following cycle, unless a refresh is pending.
- R2: If the addressed bank holds the requested row, `hit_pulse` is high in the acceptance cycle. The only command for that request is READ/WRITE, driven in the cycle after acceptance.
- R3: If the addressed bank has no open row, `miss_pulse` is high in the acceptance cycle. ACTIVATE with the new row follows in the next cycle, provided the bank's close-to-open gap has elapsed. READ/WRITE follows exactly `T_RCD` cycles after the ACTIVATE.
- R4: If the addressed bank holds a different row, `miss_pulse` is high in the acceptance cycle. The request then produces three commands: PRECHARGE of that bank, ACTIVATE exactly `T_RP` cycles later, and READ/WRITE exactly `T_RCD` cycles after that.
- R5: A bank is never precharged sooner than `T_RAS` cycles after its ACTIVATE. The PRECHARGE of R4 is driven in the later of two cycles: the cycle after acceptance, or the bank's ACTIVATE cycle plus `T_RAS`.
- R6: `cmd_op` encodes the command as 0 for none, 1 for ACTIVATE, 2 for READ, 3 for WRITE, 4 for PRECHARGE and 5 for REFRESH. `cmd_valid` is high exactly when `cmd_op` is nonzero. `cmd_bank` carries the bank, `cmd_row` carries the row for ACTIVATE, and `cmd_col` carries the column for READ/WRITE.
- R7: Refresh becomes pending every `REF_INTERVAL` cycles. When no bank is open and no request is in progress, REFRESH is driven in the first pending cycle, so two consecutive undelayed refreshes are exactly `REF_INTERVAL` cycles apart.
- R8: While a refresh is pending, each open bank is precharged, lowest index first, one bank per cycle. REFRESH is driven exactly `T_RP` cycles after the last of these PRECHARGE commands, with no other command in between.
- R9: A request that is waiting when REFRESH is driven is accepted exactly `T_RFC + 1` cycles after the REFRESH. All banks are closed after a refresh, so that request is a miss.
- R10: After reset, `req_ready` is high, no command is driven, neither pulse is high, and every bank is treated as closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BW | Bank index |
| req_row | input | ROW_W | Row within the bank |
| req_col | input | COL_W | Column within the row |
| cmd_valid | output | 1 | A command is driven this cycle |
| cmd_op | output | 3 | Command code (see R6) |
| cmd_bank | output | BW | Target bank |
| cmd_row | output | ROW_W | Row address for ACTIVATE |
| cmd_col | output | COL_W | Column address for READ/WRITE |
| hit_pulse | output | 1 | Accepted request hits the open row |
| miss_pulse | output | 1 | Accepted request misses the open row |

## Verification
The hit and miss pulses are combinational on the accepted request, so they are sampled in the acceptance cycle itself. The first command of a request is due in the next cycle. Later commands follow at exact offsets set by the gap parameters, measured from the command before them, and the bench derives each expected cycle number from those offsets and its own record of ACTIVATE times per bank. A monitor logs every command with its cycle number, and each sample is taken half a clock away from the active edge. Refresh checks measure the spacing between logged PRECHARGE, REFRESH and acceptance cycles against `T_RP`, `T_RFC + 1` and `REF_INTERVAL`.

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq #(
  parameter int NBANK        = 8,
  parameter int ROW_W        = 14,
  parameter int COL_W        = 10,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RAS        = 6,
  parameter int T_RFC        = 8,
  parameter int REF_INTERVAL = 780,
  localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [BW-1:0]    req_bank,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [BW-1:0]    cmd_bank,
  output logic [ROW_W-1:0] cmd_row,
  output logic [COL_W-1:0] cmd_col,
  output logic             hit_pulse,
  output logic             miss_pulse
);

  localparam logic [2:0] OP_NOP = 3'd0;
  localparam logic [2:0] OP_ACT = 3'd1;
  localparam logic [2:0] OP_RD  = 3'd2;
  localparam logic [2:0] OP_WR  = 3'd3;
  localparam logic [2:0] OP_PRE = 3'd4;
  localparam logic [2:0] OP_REF = 3'd5;

  localparam int G1   = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int G2   = (T_RAS > T_RFC) ? T_RAS : T_RFC;
  localparam int MAXG = (G1 > G2) ? G1 : G2;
  localparam int CW   = $clog2(MAXG + 1);
  localparam int TW   = $clog2(REF_INTERVAL + 1);

  typedef enum logic [1:0] {S_IDLE, S_BUSY, S_REF} st_t;

  st_t              st;
  logic [NBANK-1:0] open_q;
  logic [ROW_W-1:0] open_row [NBANK];
  logic [CW-1:0]    rcd_cnt  [NBANK];
  logic [CW-1:0]    ras_cnt  [NBANK];
  logic [CW-1:0]    rp_cnt   [NBANK];
  logic [CW-1:0]    rfc_cnt;
  logic [TW-1:0]    ref_tmr;
  logic             ref_pend;

  logic             cur_write;
  logic [BW-1:0]    cur_bank;
  logic [ROW_W-1:0] cur_row;
  logic [COL_W-1:0] cur_col;

  logic             accept, req_match, cur_match;
  logic             pre_any, rp_all_done;
  logic [BW-1:0]    pre_bank;
  logic             is_act, is_pre, is_rw, is_ref;

  assign req_ready  = (st == S_IDLE) && !ref_pend;
  assign accept     = req_valid && req_ready;
  assign req_match  = open_q[req_bank] && (open_row[req_bank] == req_row);
  assign cur_match  = open_q[cur_bank] && (open_row[cur_bank] == cur_row);
  assign hit_pulse  = accept && req_match;
  assign miss_pulse = accept && !req_match;

  always_comb begin
    pre_any     = 1'b0;
    pre_bank    = '0;
    rp_all_done = 1'b1;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (open_q[b]) begin
        pre_any  = 1'b1;
        pre_bank = BW'(b);
      end
      if (rp_cnt[b] != '0) rp_all_done = 1'b0;
    end
  end

  always_comb begin
    cmd_op   = OP_NOP;
    cmd_bank = cur_bank;
    cmd_row  = cur_row;
    cmd_col  = cur_col;
    case (st)
      S_BUSY: begin
        if (cur_match) begin
          if (rcd_cnt[cur_bank] == '0) cmd_op = cur_write ? OP_WR : OP_RD;
        end else if (open_q[cur_bank]) begin
          if (ras_cnt[cur_bank] == '0) cmd_op = OP_PRE;
        end else if (rp_cnt[cur_bank] == '0) begin
          cmd_op = OP_ACT;
        end
      end
      S_IDLE: begin
        if (ref_pend) begin
          if (pre_any) begin
            cmd_bank = pre_bank;
            if (ras_cnt[pre_bank] == '0) cmd_op = OP_PRE;
          end else if (rp_all_done) begin
            cmd_op = OP_REF;
          end
        end
      end
      default: cmd_op = OP_NOP;
    endcase
  end

  assign cmd_valid = (cmd_op != OP_NOP);
  assign is_act    = (cmd_op == OP_ACT);
  assign is_pre    = (cmd_op == OP_PRE);
  assign is_rw     = (cmd_op == OP_RD) || (cmd_op == OP_WR);
  assign is_ref    = (cmd_op == OP_REF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      open_q    <= '0;
      ref_pend  <= 1'b0;
      ref_tmr   <= TW'(REF_INTERVAL - 1);
      rfc_cnt   <= '0;
      cur_write <= 1'b0;
      cur_bank  <= '0;
      cur_row   <= '0;
      cur_col   <= '0;
      for (int b = 0; b < NBANK; b++) begin
        open_row[b] <= '0;
        rcd_cnt[b]  <= '0;
        ras_cnt[b]  <= '0;
        rp_cnt[b]   <= '0;
      end
    end else begin
      for (int b = 0; b < NBANK; b++) begin
        if (is_act && cmd_bank == BW'(b)) begin
          open_q[b]   <= 1'b1;
          open_row[b] <= cmd_row;
          rcd_cnt[b]  <= CW'(T_RCD - 1);
          ras_cnt[b]  <= CW'(T_RAS - 1);
        end else begin
          if (rcd_cnt[b] != '0) rcd_cnt[b] <= rcd_cnt[b] - 1'b1;
          if (ras_cnt[b] != '0) ras_cnt[b] <= ras_cnt[b] - 1'b1;
        end
        if (is_pre && cmd_bank == BW'(b)) begin
          open_q[b] <= 1'b0;
          rp_cnt[b] <= CW'(T_RP - 1);
        end else if (rp_cnt[b] != '0) begin
          rp_cnt[b] <= rp_cnt[b] - 1'b1;
        end
      end

      if (is_ref) ref_pend <= 1'b0;
      if (ref_tmr == '0) begin
        ref_tmr  <= TW'(REF_INTERVAL - 1);
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr - 1'b1;
      end

      case (st)
        S_IDLE: begin
          if (accept) begin
            st        <= S_BUSY;
            cur_write <= req_write;
            cur_bank  <= req_bank;
            cur_row   <= req_row;
            cur_col   <= req_col;
          end else if (is_ref) begin
            st      <= S_REF;
            rfc_cnt <= CW'(T_RFC - 1);
          end
        end
        S_BUSY: if (is_rw) st <= S_IDLE;
        S_REF: begin
          if (rfc_cnt == '0) st <= S_IDLE;
          else rfc_cnt <= rfc_cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Independent per-bank age counters used only by the checks below
  localparam logic [7:0] A_RCD = 8'(T_RCD);
  localparam logic [7:0] A_RP  = 8'(T_RP);
  localparam logic [7:0] A_RAS = 8'(T_RAS);

  logic [7:0] since_act [NBANK];
  logic [7:0] since_pre [NBANK];
  logic       all_pre_aged;

  always_ff @(posedge clk) begin
    for (int b = 0; b < NBANK; b++) begin
      if (!rst_n) begin
        since_act[b] <= 8'hFF;
        since_pre[b] <= 8'hFF;
      end else begin
        if (cmd_op == OP_ACT && cmd_bank == BW'(b)) since_act[b] <= 8'd1;
        else if (since_act[b] != 8'hFF) since_act[b] <= since_act[b] + 8'd1;
        if (cmd_op == OP_PRE && cmd_bank == BW'(b)) since_pre[b] <= 8'd1;
        else if (since_pre[b] != 8'hFF) since_pre[b] <= since_pre[b] + 8'd1;
      end
    end
  end

  always_comb begin
    all_pre_aged = 1'b1;
    for (int b = 0; b < NBANK; b++)
      if (since_pre[b] < A_RP) all_pre_aged = 1'b0;
  end

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r2_pulse_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_pulse, miss_pulse}));

  a_r3_act_to_column: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_RD || cmd_op == OP_WR) |-> since_act[cmd_bank] >= A_RCD);

  a_r4_pre_to_act: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_ACT) |-> since_pre[cmd_bank] >= A_RP);

  a_r5_act_to_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_PRE) |-> since_act[cmd_bank] >= A_RAS);

  a_r8_refresh_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_REF) |-> (open_q == '0) && all_pre_aged);

endmodule

// File: tb/dram_cmd_seq_test.sv
module dram_cmd_seq_test;

  localparam int NB   = 8;
  localparam int RW   = 14;
  localparam int CL   = 10;
  localparam int TRCD = 3;
  localparam int TRP  = 3;
  localparam int TRAS = 6;
  localparam int TRFC = 8;
  localparam int RINT = 400;

  // 8 ns period (125 MHz)
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n, req_valid, req_ready, req_write;
  logic [2:0]    req_bank;
  logic [RW-1:0] req_row;
  logic [CL-1:0] req_col;
  logic          cmd_valid;
  logic [2:0]    cmd_op;
  logic [2:0]    cmd_bank;
  logic [RW-1:0] cmd_row;
  logic [CL-1:0] cmd_col;
  logic          hit_pulse, miss_pulse;

  dram_cmd_seq #(.NBANK(NB), .ROW_W(RW), .COL_W(CL), .T_RCD(TRCD), .T_RP(TRP),
                 .T_RAS(TRAS), .T_RFC(TRFC), .REF_INTERVAL(RINT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .cmd_col(cmd_col), .hit_pulse(hit_pulse), .miss_pulse(miss_pulse));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int nchk = 0, nfail = 0;
  int lg_op [1024], lg_cyc [1024], lg_bank [1024], lg_row [1024], lg_col [1024];
  int nlog = 0;

  always @(negedge clk)
    if (rst_n && cmd_valid && nlog < 1024) begin
      lg_op[nlog]   = int'(cmd_op);
      lg_cyc[nlog]  = cyc;
      lg_bank[nlog] = int'(cmd_bank);
      lg_row[nlog]  = int'(cmd_row);
      lg_col[nlog]  = int'(cmd_col);
      nlog = nlog + 1;
    end

  int  act_m [NB];
  logic open_m [NB];

  // {kind: 0 hit, 1 closed, 2 conflict; write; bank; row; col}
  localparam logic [29:0] VEC [14] = '{
    {2'd1, 1'b0, 3'd0, 14'd5,     10'd3},
    {2'd0, 1'b1, 3'd0, 14'd5,     10'd4},
    {2'd2, 1'b0, 3'd0, 14'd9,     10'd0},
    {2'd1, 1'b1, 3'd7, 14'd16383, 10'd1023},
    {2'd0, 1'b0, 3'd7, 14'd16383, 10'd0},
    {2'd1, 1'b0, 3'd3, 14'd0,     10'd7},
    {2'd2, 1'b1, 3'd3, 14'd1,     10'd8},
    {2'd0, 1'b0, 3'd0, 14'd9,     10'd9},
    {2'd1, 1'b0, 3'd1, 14'd9,     10'd2},
    {2'd2, 1'b1, 3'd7, 14'd0,     10'd5},
    {2'd0, 1'b1, 3'd3, 14'd1,     10'd6},
    {2'd2, 1'b0, 3'd1, 14'd100,   10'd1},
    {2'd0, 1'b0, 3'd1, 14'd100,   10'd1023},
    {2'd1, 1'b1, 3'd5, 14'd2,     10'd11}
  };

  task automatic chk(input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic do_req(input logic [29:0] v, output int acc);
    int k, b, r, c, start, ridx, gh, gm, pre_exp, act_exp, rw_exp, ai;
    string tag;
    k = int'(v[29:28]); b = int'(v[26:24]); r = int'(v[23:10]); c = int'(v[9:0]);
    tag = (k == 0) ? "R2" : (k == 1) ? "R3" : "R4";
    start = nlog;
    req_write = v[27]; req_bank = v[26:24]; req_row = v[23:10]; req_col = v[9:0];
    req_valid = 1'b1;
    acc = -1; gh = 0; gm = 0;
    for (int i = 0; i < 2000; i++) begin
      #1;
      if (req_ready) begin acc = cyc; gh = int'(hit_pulse); gm = int'(miss_pulse); break; end
      @(negedge clk);
    end
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk); #1;
    chk("R1 ready low while busy", int'(req_ready), 0);
    chk({tag, " hit_pulse"}, gh, (k == 0) ? 1 : 0);
    chk({tag, " miss_pulse"}, gm, (k == 0) ? 0 : 1);
    ridx = -1;
    for (int i = 0; i < 100; i++) begin
      for (int j = start; j < nlog; j++)
        if (ridx < 0 && (lg_op[j] == 2 || lg_op[j] == 3)) ridx = j;
      if (ridx >= 0) break;
      @(negedge clk); #1;
    end
    if (ridx < 0) begin
      chk({tag, " column command seen"}, 0, 1);
      return;
    end
    chk({tag, " command count"}, ridx - start + 1, k + 1);
    if (ridx - start + 1 == k + 1) begin
      act_exp = acc + 1;
      if (k == 2) begin
        pre_exp = (acc + 1 > act_m[b] + TRAS) ? acc + 1 : act_m[b] + TRAS;
        chk("R6 PRE code", lg_op[start], 4);
        chk("R5 PRE cycle", lg_cyc[start], pre_exp);
        chk("R4 PRE bank", lg_bank[start], b);
        act_exp = pre_exp + TRP;
      end
      if (k >= 1) begin
        ai = start + k - 1;
        chk("R6 ACT code", lg_op[ai], 1);
        chk({tag, " ACT cycle"}, lg_cyc[ai], act_exp);
        chk("R6 ACT row", lg_row[ai], r);
        chk("R6 ACT bank", lg_bank[ai], b);
        act_m[b] = act_exp;
        rw_exp = act_exp + TRCD;
      end else begin
        rw_exp = acc + 1;
      end
      chk("R6 column code", lg_op[ridx], v[27] ? 3 : 2);
      chk({tag, " column cycle"}, lg_cyc[ridx], rw_exp);
      chk("R6 column bank", lg_bank[ridx], b);
      chk("R6 column address", lg_col[ridx], c);
    end
    open_m[b] = 1'b1;
    @(negedge clk); #1;
    chk("R1 ready after column command", int'(req_ready), 1);
  endtask

  task automatic wait_ref(input int from, output int idx);
    idx = -1;
    for (int i = 0; i < 3000; i++) begin
      for (int j = from; j < nlog; j++)
        if (idx < 0 && lg_op[j] == 5) idx = j;
      if (idx >= 0) break;
      @(negedge clk); #1;
    end
    if (idx < 0) chk("R7 REFRESH seen", 0, 1);
  endtask

  initial begin
    int acc, tend, n, r1, r2, r3, r4, t2;
    logic [29:0] after_ref;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_bank = '0; req_row = '0; req_col = '0;
    for (int b = 0; b < NB; b++) begin act_m[b] = -100; open_m[b] = 1'b0; end
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 ready after reset", int'(req_ready), 1);
    chk("R10 no command after reset", int'(cmd_valid), 0);
    chk("R10 idle code after reset", int'(cmd_op), 0);
    chk("R10 no pulse after reset", int'(hit_pulse | miss_pulse), 0);

    for (int i = 0; i < 14; i++) do_req(VEC[i], acc);

    // Refresh with several open banks
    tend = nlog;
    wait_ref(tend, r1);
    if (r1 >= 0) begin
      n = 0;
      for (int b = 0; b < NB; b++)
        if (open_m[b]) begin
          if (tend + n < r1) begin
            chk("R8 PRE code", lg_op[tend + n], 4);
            chk("R8 PRE order", lg_bank[tend + n], b);
            chk("R8 one PRE per cycle", lg_cyc[tend + n] - lg_cyc[tend], n);
          end
          n++;
        end
      chk("R8 commands before REFRESH", r1 - tend, n);
      if (r1 > tend) chk("R8 REFRESH after last PRE", lg_cyc[r1] - lg_cyc[r1 - 1], TRP);
      for (int b = 0; b < NB; b++) open_m[b] = 1'b0;

      after_ref = {2'd1, 1'b0, 3'd0, 14'd9, 10'd0};
      do_req(after_ref, acc);
      chk("R9 accept after refresh", acc, lg_cyc[r1] + TRFC + 1);

      t2 = nlog;
      wait_ref(t2, r2);
      if (r2 >= 0) begin
        chk("R8 single PRE before REFRESH", r2 - t2, 1);
        if (r2 > t2) begin
          chk("R8 PRE bank", lg_bank[t2], 0);
          chk("R8 REFRESH gap", lg_cyc[r2] - lg_cyc[t2], TRP);
        end
        wait_ref(r2 + 1, r3);
        if (r3 >= 0) begin
          chk("R7 no command between refreshes", r3, r2 + 1);
          chk("R7 delayed refresh spacing", lg_cyc[r3] - lg_cyc[r2], RINT - TRP);
          wait_ref(r3 + 1, r4);
          if (r4 >= 0) chk("R7 idle refresh spacing", lg_cyc[r4] - lg_cyc[r3], RINT);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    nfail++;
    nchk++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule